// File: doc/BRIEF.md
# Multi-Channel Pulse-Width DAC Bank

This block holds fourteen pulse-width modulators that share one period counter running on the system clock. Each channel has its own 8-bit duty code. Over one period, a channel's output stays high for a number of clocks equal to its code. The output is a digital stand-in for an open-drain pin. It consists of a logic level plus a pull-low enable, which is always the inverse of that level. An external RC filter turns the pulse train into an analog voltage.

A processor-style register port writes and reads the duty codes and one control register. The control register picks the period length: 256 clocks (long mode) or 253 clocks (short mode). In short mode the three highest codes saturate to a steady high. In long mode the highest code still leaves one low clock in each period.

Writes first land in a shadow bank. The active copy is updated only at the period boundary, so a channel never produces a shortened or stretched pulse. The period counter is driven by a two-state sequencer:

- **SEQ_RUN** counts up through the period.
- **RUN→LAST**: the sequencer moves to **SEQ_LAST** when the counter reaches one below the final position.
- **SEQ_LAST** covers the final clock of the period.
- **LAST→RUN**: this transition is taken unconditionally. It clears the counter and commits the shadow bank to the active bank.
- **RUN→RUN**: the sequencer stays in SEQ_RUN on every other clock.

Top module: `pwm_dac_array`

## Requirements
- R1: A channel's level is high in each clock where the shared period counter is below the channel's active code, and low otherwise. The counter is 0 in the first clock of every period.
- R2: The period is 256 clocks when bit 0 of the control register (address 14) is 0, and 253 clocks when it is 1. The counter steps by one per clock and returns to 0 after the last position.
- R3: In short mode, codes FDh, FEh and FFh hold the level high for every clock of the period.
- R4: In long mode, code FFh gives 255 high clocks and is low in the final clock of each period.
- R5: Code 00h holds the level low for the whole period in both modes.
- R6: After reset every duty code reads 80h and the control register reads 0 (long mode). The first period therefore gives 128 high clocks on every channel.
- R7: A write to a channel (addresses 0 to 13) or to the control register changes only the shadow copy. It takes effect at the next period boundary, and the period in progress finishes with the old settings.
- R8: Reads are combinational and return the value most recently written to that address. Address 15 reads 00h, and writes to it change nothing.
- R9: Each channel's pull-low enable is the inverse of its level in every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one counter step per edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | AW (4) | Register address: 0-13 channel codes, 14 control, 15 reserved |
| reg_wdata | input | DW (8) | Write data |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_rdata | output | DW (8) | Read data for reg_addr (shadow value) |
| dac_lvl | output | CH_NUM (14) | Per-channel PWM level |
| dac_pull_en | output | CH_NUM (14) | Per-channel pull-low enable (inverse of level) |

## Verification
Some behaviours are checked by assertions on every clock:

- the counter stepping and wrapping at the position set by the active mode (R2);
- the active codes and mode staying frozen inside a period (R7);
- the saturation rules: zero code low (R5), short-mode top codes high (R3), and the long-mode final clock low (R4).

Other behaviours only the bench scenarios can show. These are the exact number of high clocks each code yields over a whole period, and the period length measured between rising edges on the pins. They also include the fact that a write made mid-period leaves that period untouched. Finally, they cover readback values and the reserved address.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    // Period sequencer states
    typedef enum logic [0:0] {
        SEQ_RUN  = 1'b0,   // counting inside the period
        SEQ_LAST = 1'b1    // final clock of the period; commit on exit
    } seq_state_e;

endpackage

// File: rtl/pwm_dac_seq.sv
module pwm_dac_seq
    import pwm_dac_pkg::*;
#(
    parameter int LONG_LEN  = 256,
    parameter int SHORT_LEN = 253,
    parameter int CW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          short_mode,
    output logic [CW-1:0] cnt_q,
    output logic          commit
);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] last_pos;

    assign last_pos = short_mode ? CW'(SHORT_LEN - 1) : CW'(LONG_LEN - 1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_RUN: begin
                if (cnt_q == CW'(last_pos - 1'b1)) begin
                    state_d = SEQ_LAST;
                end
            end
            SEQ_LAST: begin
                state_d = SEQ_RUN;
            end
            default: state_d = SEQ_RUN;
        endcase
    end

    // Output logic
    always_comb begin
        commit = 1'b0;
        cnt_d  = CW'(cnt_q + 1'b1);
        unique case (state_q)
            SEQ_RUN: begin
                commit = 1'b0;
                cnt_d  = CW'(cnt_q + 1'b1);
            end
            SEQ_LAST: begin
                commit = 1'b1;
                cnt_d  = '0;
            end
            default: begin
                commit = 1'b0;
                cnt_d  = '0;
            end
        endcase
    end

endmodule

// File: rtl/pwm_dac_regs.sv
module pwm_dac_regs #(
    parameter int          CH_NUM   = 14,
    parameter int          DW       = 8,
    parameter int          AW       = 4,
    parameter int unsigned RST_CODE = 'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    input  logic                 reg_we,
    output logic [DW-1:0]        reg_rdata,
    input  logic                 commit,
    output logic [CH_NUM*DW-1:0] duty_act_flat,
    output logic                 short_act
);

    localparam logic [AW-1:0] CTRL_ADDR = AW'(CH_NUM);

    logic [DW-1:0] shd_q [CH_NUM];
    logic [DW-1:0] act_q [CH_NUM];
    logic          ctrl_shd_q;

    // Per-channel shadow and active copies
    for (genvar g = 0; g < CH_NUM; g++) begin : g_chan_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shd_q[g] <= DW'(RST_CODE);
            end else if (reg_we && (reg_addr == AW'(g))) begin
                shd_q[g] <= reg_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_q[g] <= DW'(RST_CODE);
            end else if (commit) begin
                act_q[g] <= shd_q[g];
            end
        end

        assign duty_act_flat[g*DW +: DW] = act_q[g];
    end

    // Control register: bit 0 selects the short period
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_shd_q <= 1'b0;
        end else if (reg_we && (reg_addr == CTRL_ADDR)) begin
            ctrl_shd_q <= reg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_act <= 1'b0;
        end else if (commit) begin
            short_act <= ctrl_shd_q;
        end
    end

    // Read path returns shadow contents
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < CH_NUM; i++) begin
            if (reg_addr == AW'(i)) begin
                reg_rdata = shd_q[i];
            end
        end
        if (reg_addr == CTRL_ADDR) begin
            reg_rdata = {{(DW-1){1'b0}}, ctrl_shd_q};
        end
    end

endmodule

// File: rtl/pwm_dac_chan.sv
module pwm_dac_chan #(
    parameter int DW = 8,
    parameter int CW = 8
) (
    input  logic [CW-1:0] cnt,
    input  logic [DW-1:0] duty,
    output logic          lvl,
    output logic          pull_en
);

    assign lvl     = (32'(cnt) < 32'(duty));
    assign pull_en = ~lvl;

endmodule

// File: rtl/pwm_dac_array.sv
module pwm_dac_array #(
    parameter int          CH_NUM    = 14,
    parameter int          DW        = 8,
    parameter int          AW        = 4,
    parameter int          LONG_LEN  = 256,
    parameter int          SHORT_LEN = 253,
    parameter int unsigned RST_CODE  = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              reg_we,
    output logic [DW-1:0]     reg_rdata,
    output logic [CH_NUM-1:0] dac_lvl,
    output logic [CH_NUM-1:0] dac_pull_en
);

    localparam int CW = $clog2(LONG_LEN);

    logic [CW-1:0]        cnt_q;
    logic                 commit;
    logic                 short_act;
    logic [CH_NUM*DW-1:0] duty_act_flat;

    pwm_dac_seq #(
        .LONG_LEN (LONG_LEN),
        .SHORT_LEN(SHORT_LEN),
        .CW       (CW)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .short_mode(short_act),
        .cnt_q     (cnt_q),
        .commit    (commit)
    );

    pwm_dac_regs #(
        .CH_NUM  (CH_NUM),
        .DW      (DW),
        .AW      (AW),
        .RST_CODE(RST_CODE)
    ) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_we       (reg_we),
        .reg_rdata    (reg_rdata),
        .commit       (commit),
        .duty_act_flat(duty_act_flat),
        .short_act    (short_act)
    );

    for (genvar g = 0; g < CH_NUM; g++) begin : g_chan
        pwm_dac_chan #(
            .DW(DW),
            .CW(CW)
        ) chan_i (
            .cnt    (cnt_q),
            .duty   (duty_act_flat[g*DW +: DW]),
            .lvl    (dac_lvl[g]),
            .pull_en(dac_pull_en[g])
        );
    end

endmodule

// File: rtl/pwm_dac_array_chk.sv
module pwm_dac_array_chk #(
    parameter int CH_NUM    = 14,
    parameter int DW        = 8,
    parameter int CW        = 8,
    parameter int LONG_LEN  = 256,
    parameter int SHORT_LEN = 253
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [CW-1:0]        cnt,
    input logic                 short_mode,
    input logic [CH_NUM*DW-1:0] duty_flat,
    input logic [CH_NUM-1:0]    lvl
);

    logic [CW-1:0] last_pos;
    assign last_pos = short_mode ? CW'(SHORT_LEN - 1) : CW'(LONG_LEN - 1);

    AST_WRAP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (short_mode && cnt == CW'(SHORT_LEN - 1)) |=> (cnt == '0)); // R2
    AST_WRAP_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (!short_mode && cnt == CW'(LONG_LEN - 1)) |=> (cnt == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != last_pos) |=> (cnt == CW'($past(cnt) + 1'b1))); // R2
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(duty_flat)); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(short_mode)); // R7

    for (genvar g = 0; g < CH_NUM; g++) begin : g_ch_chk
        AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_flat[g*DW +: DW] == '0) |-> !lvl[g]); // R5
        AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (short_mode && 32'(duty_flat[g*DW +: DW]) >= SHORT_LEN) |-> lvl[g]); // R3
        AST_LAST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (!short_mode && cnt == CW'(LONG_LEN - 1)) |-> !lvl[g]); // R4
    end

endmodule

bind pwm_dac_array pwm_dac_array_chk #(
    .CH_NUM   (CH_NUM),
    .DW       (DW),
    .CW       (CW),
    .LONG_LEN (LONG_LEN),
    .SHORT_LEN(SHORT_LEN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_q),
    .short_mode(short_act),
    .duty_flat (duty_act_flat),
    .lvl       (dac_lvl)
);

// File: tb/pwm_dac_array_tb_top.sv
module pwm_dac_array_tb_top;

    localparam int CH = 14;
    localparam int DW = 8;
    localparam int AW = 4;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr  = '0;
    logic [DW-1:0] wdata = '0;
    logic          we    = 1'b0;
    logic [DW-1:0] rdata;
    logic [CH-1:0] lvl;
    logic [CH-1:0] pull;

    always #2 clk = ~clk;

    pwm_dac_array dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (addr),
        .reg_wdata  (wdata),
        .reg_we     (we),
        .reg_rdata  (rdata),
        .dac_lvl    (lvl),
        .dac_pull_en(pull)
    );

    int n_chk    = 0;
    int n_fail   = 0;
    int pos      = 0;
    int cur_len  = 256;
    int pend_len = 256;
    bit mon_busy = 1'b0;

    typedef struct {
        int    ch;
        int    exp_hi;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];

    // Independent period position tracker (R2, R7)
    always @(posedge clk) begin
        if (!rst_n) begin
            pos     <= 0;
            cur_len <= 256;
        end else if (pos == cur_len - 1) begin
            pos     <= 0;
            cur_len <= pend_len;
        end else begin
            pos <= pos + 1;
        end
    end

    task automatic check(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic reg_write(int a, int d);
        @(negedge clk);
        addr  = AW'(a);
        wdata = DW'(d);
        we    = 1'b1;
        @(negedge clk);
        we = 1'b0;
        if (a == CH) pend_len = ((d & 1) != 0) ? 253 : 256;
    endtask

    task automatic reg_read(int a, output int d);
        @(negedge clk);
        addr = AW'(a);
        #1;
        d = int'(rdata);
    endtask

    task automatic wait_pos(int p);
        do @(negedge clk); while (pos != p);
    endtask

    function automatic string tag_for(int code, bit shrt);
        if (code == 0)                return "R5";
        if (shrt && code >= 253)      return "R3";
        if (!shrt && code == 255)     return "R4";
        return "R1";
    endfunction

    // Driver side: push expected high-clock counts for one future period
    task automatic push_period(input int c[CH], bit shrt, string extra);
        exp_item_t it;
        int len = shrt ? 253 : 256;
        for (int ch = 0; ch < CH; ch++) begin
            it.ch     = ch;
            it.exp_hi = (c[ch] < len) ? c[ch] : len;
            it.tag    = {tag_for(c[ch], shrt), " ", extra};
            exp_q.push_back(it);
        end
    endtask

    task automatic measure_len(int ch, output int n);
        bit prev;
        bit cur;
        bit rise;
        n    = 0;
        prev = lvl[ch];
        do begin
            @(negedge clk);
            n++;
            cur  = lvl[ch];
            rise = cur && !prev;
            prev = cur;
        end while (!rise);
    endtask

    // Monitor: measure a whole period and compare against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pos == 0 && exp_q.size() >= CH) begin
                exp_item_t items[CH];
                int        hi[CH];
                int        len;
                int        bad;
                mon_busy = 1'b1;
                len      = cur_len;
                bad      = 0;
                for (int c = 0; c < CH; c++) begin
                    items[c] = exp_q.pop_front();
                    hi[c]    = 0;
                end
                for (int k = 0; k < len; k++) begin
                    if (k > 0) @(negedge clk);
                    for (int c = 0; c < CH; c++) begin
                        if (lvl[c]) hi[c]++;
                        if (pull[c] === lvl[c]) bad++;
                    end
                end
                for (int c = 0; c < CH; c++) begin
                    check(items[c].tag, hi[items[c].ch], items[c].exp_hi,
                          $sformatf("ch%0d high clocks per period", items[c].ch));
                end
                check("R9", bad, 0, "pull-low enable not inverse of level (count)");
                mon_busy = 1'b0;
            end
        end
    end

    initial begin
        int codes[CH] = '{'h00, 'h01, 'h7F, 'hFE, 'hFF, 'h80, 'h40,
                          'hC3, 'h10, 'hFD, 'h02, 'h55, 'hAA, 'hFC};
        int rd;
        int plen;
        int rst_codes[CH];

        // Period 0: reset mid-scale; mid-period writes must not disturb it
        for (int c = 0; c < CH; c++) rst_codes[c] = 'h80;
        push_period(rst_codes, 1'b0, "R6 R7");

        repeat (3) @(negedge clk);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R6: reset values read back
        for (int a = 0; a < CH; a++) begin
            reg_read(a, rd);
            check("R6", rd, 'h80, $sformatf("reset code of ch%0d", a));
        end
        reg_read(CH, rd);
        check("R6", rd, 0, "reset control register");
        reg_read(15, rd);
        check("R8", rd, 0, "reserved address read");

        // Write new codes mid-period 0
        wait_pos(40);
        for (int c = 0; c < CH; c++) reg_write(c, codes[c]);
        push_period(codes, 1'b0, "R7");

        // R8: reserved address ignores writes
        reg_write(15, 'h5A);
        reg_read(15, rd);
        check("R8", rd, 0, "reserved address after write");
        for (int a = 0; a < CH; a++) begin
            reg_read(a, rd);
            check("R8", rd, codes[a], $sformatf("readback ch%0d", a));
        end

        // Period 1: select the short period; it applies from period 2
        wait_pos(0);
        wait_pos(10);
        reg_write(CH, 1);
        reg_read(CH, rd);
        check("R8", rd, 1, "control readback");
        push_period(codes, 1'b1, "R2");

        // Period 2: rising-edge spacing of a code-01h channel
        wait_pos(0);
        measure_len(1, plen);
        check("R2", plen, 253, "short period length");

        // Period 3: back to long mode, top code on channel 13
        wait_pos(10);
        reg_write(CH, 0);
        codes[13] = 'hFF;
        reg_write(13, codes[13]);
        push_period(codes, 1'b0, "R2");

        wait_pos(0);
        measure_len(1, plen);
        check("R2", plen, 256, "long period length");

        wait (exp_q.size() == 0 && !mon_busy);
        @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected run completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule